// File: doc/BRIEF.md
# Periodic Rate and Interrupt Controller

This block sits next to a calendar engine in a timekeeping subsystem. It runs a fifteen-stage binary divider off a 32.768 kHz clock enable. A four-bit rate code picks one divider stage. That stage feeds both a square-wave pin and a periodic event. The most significant stage also yields a once-per-second strobe for the calendar counters.

The block keeps three event flags: periodic, alarm and update-ended. Each flag has its own enable. From these it forms a summary interrupt bit and drives an open-drain interrupt request, modelled as an active-low output enable. Software reads the flags through a status byte that clears when read. The byte is frozen for the whole read. Any event that arrives during the read is kept and posted when the read ends.

Top module: `periodic_irq_unit`

## Requirements
- R1: The rate code (control-A write, bits 3:0) selects the tap that feeds both the square wave and the periodic event. Code 0 gives no tap. Codes 1 and 2 give periods of 128 and 256 ticks. Codes 3 to 15 give a period of 2^(code-1) ticks with a 50% duty cycle.
- R2: `sqwOut` follows the selected tap while the square-wave enable (control-B bit 3) is 1. It stays low while that enable is 0.
- R3: The divider control (control-A bits 6:4) works as follows. Pattern 010 runs the chain. Patterns 110 and 111 hold it at zero. All other patterns freeze it. After a move from hold to 010, the first `secTick` comes 16384 ticks after the write, and then one comes every 32768 ticks.
- R4: The periodic flag sets on each rising edge of the selected tap, whatever the value of the periodic enable.
- R5: `statusByte` carries the summary bit in bit 7, and the periodic, alarm and update flags in bits 6, 5 and 4. Bits 3:0 read zero. The summary bit equals PF·PIE + AF·AIE + UF·UIE, with enables in control-B bits 6, 5 and 4. `irqOeN` is 0 exactly when the summary bit is 1, and `irqLine` is always 0. Enabling a source whose flag is already set asserts the request at once.
- R6: While `statRd` is high, `statusByte` keeps the value that was live when the read began. All flags clear when the read begins.
- R7: A flag event that arrives during a read does not show in the held byte. It is set in the flags when `statRd` falls.
- R8: A control-B write with bit 7 (freeze-updates) set clears the update enable, whatever bit 4 holds.
- R9: `rstN` low clears all three enables, the square-wave enable and all flags, and releases the request (`irqOeN` = 1). It leaves the rate code, the divider control and the divider count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | 32.768 kHz clock enable that advances the divider |
| ctlAWr | input | 1 | Write strobe for divider control and rate code |
| ctlBWr | input | 1 | Write strobe for enables and freeze-updates bit |
| wrData | input | 8 | Write data shared by both control writes |
| statRd | input | 1 | Held high for the duration of a status read |
| alarmEv | input | 1 | One-cycle alarm-match pulse from the calendar engine |
| updEv | input | 1 | One-cycle update-ended pulse from the calendar engine |
| statusByte | output | 8 | Status value: summary bit and flags |
| irqOeN | output | 1 | Active-low output enable of the open-drain request |
| irqLine | output | 1 | Value driven on the request line when enabled (0) |
| sqwOut | output | 1 | Square-wave output |
| secTick | output | 1 | Once-per-second strobe for the calendar engine |

## Verification
The hardest case to reach is an event that lands inside a status read. The byte must not change mid-read, and the event must still appear once the read ends. The bench holds `statRd` high over several cycles and pulses an update event in the middle. It checks that the held byte still shows only the flags from before the read. After `statRd` falls, it checks that the late flag alone has appeared. A second hard case is the exact delay from releasing the divider hold to the first one-second strobe. The bench clears the chain with a hold pattern, starts it with a single write, and counts cycles up to the first and second strobes.

// File: rtl/piu_pkg.sv
package piu_pkg;
  localparam int FLAG_N = 3;
  localparam int FL_PF  = 2;
  localparam int FL_AF  = 1;
  localparam int FL_UF  = 0;

  typedef logic [FLAG_N-1:0] flagVec_t;

  typedef struct packed {
    logic rdStart;
    logic rdHold;
    logic rdEnd;
    logic showSnap;
    logic chainRun;
    logic chainClr;
  } ctlStrobes_t;
endpackage

// File: rtl/piu_ctrl.sv
module piu_ctrl
  import piu_pkg::*;
#(
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlAWr,
  input  logic              ctlBWr,
  input  logic [7:0]        wrData,
  input  logic              statRd,
  output ctlStrobes_t       strb,
  output logic [RATE_W-1:0] rateSel,
  output flagVec_t          enables,
  output logic              sqwe
);
  logic [2:0] divCtl;
  logic       rdQ;

  // rate code and divider control survive reset
  always_ff @(posedge clk) begin
    if (ctlAWr && rstN) begin
      divCtl  <= wrData[6:4];
      rateSel <= wrData[RATE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enables <= '0;
      sqwe    <= 1'b0;
      rdQ     <= 1'b0;
    end else begin
      rdQ <= statRd;
      if (ctlBWr) begin
        enables[FL_PF] <= wrData[6];
        enables[FL_AF] <= wrData[5];
        enables[FL_UF] <= wrData[4] & ~wrData[7];
        sqwe           <= wrData[3];
      end
    end
  end

  always_comb begin
    strb.rdStart  = statRd & ~rdQ;
    strb.rdHold   = statRd;
    strb.rdEnd    = ~statRd & rdQ;
    strb.showSnap = statRd & rdQ;
    strb.chainRun = (divCtl == 3'b010);
    strb.chainClr = (divCtl[2:1] == 2'b11);
  end

  // R8: freeze-updates write drops the update enable
  p_set_clears_uie_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctlBWr && wrData[7]) |=> !enables[FL_UF]);
endmodule

// File: rtl/piu_divider.sv
module piu_divider
  import piu_pkg::*;
#(
  parameter int STAGES = 15,
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  ctlStrobes_t       strb,
  input  logic [RATE_W-1:0] rateSel,
  input  logic              sqwe,
  output logic              pfEv,
  output logic              sqwOut,
  output logic              secTick
);
  localparam int RATES = 2 ** RATE_W;

  logic [STAGES-1:0] cnt;
  logic [RATES-1:0]  tapVec;
  logic              tap, tapQ, msbQ;

  always_ff @(posedge clk) begin
    if (strb.chainClr)                 cnt <= '0;
    else if (strb.chainRun && tickEn)  cnt <= cnt + 1'b1;
    tapQ <= tap;
    msbQ <= cnt[STAGES-1];
  end

  assign tapVec[0] = 1'b0;
  for (genvar c = 1; c < RATES; c++) begin : g_tap
    localparam int IDX = (c == 1) ? 6 : (c == 2) ? 7 : c - 2;
    if (IDX < STAGES) begin : g_in
      assign tapVec[c] = cnt[IDX];
    end else begin : g_off
      assign tapVec[c] = 1'b0;
    end
  end

  assign tap     = tapVec[rateSel];
  assign pfEv    = tap & ~tapQ;
  assign secTick = cnt[STAGES-1] & ~msbQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sqwOut <= 1'b0;
    else       sqwOut <= sqwe & tap;
  end

  // R2: disabled square wave stays low
  p_sqw_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    !sqwe |=> !sqwOut);
  // R3: hold pattern parks the chain at zero
  p_hold_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.chainClr |=> (cnt == '0));
  // R3: neither run nor hold freezes the count
  p_freeze_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.chainRun && !strb.chainClr) |=> $stable(cnt));
endmodule

// File: rtl/piu_flagbank.sv
module piu_flagbank
  import piu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strb,
  input  logic        pfEv,
  input  logic        alarmEv,
  input  logic        updEv,
  input  flagVec_t    enables,
  output logic [7:0]  statusByte,
  output logic        irqOeN
);
  flagVec_t   flags, pend, ev;
  logic [3:0] snap;
  logic       liveIrqf;

  always_comb begin
    ev          = '0;
    ev[FL_PF]   = pfEv;
    ev[FL_AF]   = alarmEv;
    ev[FL_UF]   = updEv;
  end

  assign liveIrqf = |(flags & enables);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags <= '0;
      pend  <= '0;
      snap  <= '0;
    end else if (strb.rdStart) begin
      snap  <= {liveIrqf, flags};
      flags <= '0;
      pend  <= ev;
    end else if (strb.rdEnd) begin
      flags <= pend | ev;
      pend  <= '0;
    end else if (strb.rdHold) begin
      pend  <= pend | ev;
    end else begin
      flags <= flags | ev;
    end
  end

  assign statusByte = strb.showSnap ? {snap, 4'b0000} : {liveIrqf, flags, 4'b0000};
  assign irqOeN     = ~liveIrqf;

  // R4: periodic edge outside a read always lands in the flag
  p_pf_sets_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pfEv && !strb.rdHold) |=> flags[FL_PF]);
  // R6: start of a read empties the flags
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdStart |=> (flags == '0));
  // R7: held byte does not move during a read
  p_snap_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.showSnap |=> (!strb.showSnap || $stable(statusByte)));
  // R9: reset releases the request and empties the status
  p_reset_quiet_r9: assert property (@(posedge clk)
    !rstN |-> (irqOeN && statusByte == 8'h00));
endmodule

// File: rtl/periodic_irq_unit.sv
module periodic_irq_unit
  import piu_pkg::*;
#(
  parameter int STAGES = 15,
  parameter int RATE_W = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       ctlAWr,
  input  logic       ctlBWr,
  input  logic [7:0] wrData,
  input  logic       statRd,
  input  logic       alarmEv,
  input  logic       updEv,
  output logic [7:0] statusByte,
  output logic       irqOeN,
  output logic       irqLine,
  output logic       sqwOut,
  output logic       secTick
);
  ctlStrobes_t       strb;
  logic [RATE_W-1:0] rateSel;
  flagVec_t          enables;
  logic              sqwe, pfEv;

  piu_ctrl #(.RATE_W(RATE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctlAWr(ctlAWr), .ctlBWr(ctlBWr),
    .wrData(wrData), .statRd(statRd), .strb(strb),
    .rateSel(rateSel), .enables(enables), .sqwe(sqwe)
  );

  piu_divider #(.STAGES(STAGES), .RATE_W(RATE_W)) u_div (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strb(strb),
    .rateSel(rateSel), .sqwe(sqwe), .pfEv(pfEv),
    .sqwOut(sqwOut), .secTick(secTick)
  );

  piu_flagbank u_flags (
    .clk(clk), .rstN(rstN), .strb(strb), .pfEv(pfEv),
    .alarmEv(alarmEv), .updEv(updEv), .enables(enables),
    .statusByte(statusByte), .irqOeN(irqOeN)
  );

  assign irqLine = 1'b0;
endmodule

// File: tb/periodic_irq_unit_bench.sv
`timescale 1ns/1ps
module periodic_irq_unit_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b1;
  logic       tickEn = 1'b1;
  logic       ctlAWr = 1'b0, ctlBWr = 1'b0, statRd = 1'b0;
  logic       alarmEv = 1'b0, updEv = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] statusByte;
  logic       irqOeN, irqLine, sqwOut, secTick;

  int nChk = 0, nBad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  periodic_irq_unit u_periodic_irq_unit (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .ctlAWr(ctlAWr), .ctlBWr(ctlBWr),
    .wrData(wrData), .statRd(statRd), .alarmEv(alarmEv), .updEv(updEv),
    .statusByte(statusByte), .irqOeN(irqOeN), .irqLine(irqLine),
    .sqwOut(sqwOut), .secTick(secTick)
  );

  // {aie, uie, alarm pulse, update pulse, expected status}
  localparam logic [11:0] VEC [8] = '{
    {4'b0010, 8'h20}, {4'b1010, 8'hA0}, {4'b0110, 8'h20}, {4'b0101, 8'h90},
    {4'b1111, 8'hB0}, {4'b0011, 8'h30}, {4'b1001, 8'h10}, {4'b0000, 8'h00}
  };

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wrA(input logic [7:0] d);
    @(negedge clk); wrData = d; ctlAWr = 1'b1;
    @(negedge clk); ctlAWr = 1'b0;
  endtask

  task automatic wrB(input logic [7:0] d);
    @(negedge clk); wrData = d; ctlBWr = 1'b1;
    @(negedge clk); ctlBWr = 1'b0;
  endtask

  task automatic pulseEv(input logic af, input logic uf);
    @(negedge clk); alarmEv = af; updEv = uf;
    @(negedge clk); alarmEv = 1'b0; updEv = 1'b0;
  endtask

  task automatic readC(output logic [7:0] v);
    @(negedge clk); statRd = 1'b1;
    @(negedge clk); v = statusByte; statRd = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(output int per, output int hi);
    logic prev;
    per = 0; hi = 0;
    prev = sqwOut;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (sqwOut && !prev) break;
      prev = sqwOut;
    end
    for (int i = 0; i < 2000; i++) begin
      if (sqwOut) hi++;
      per++;
      prev = sqwOut;
      @(negedge clk);
      if (sqwOut && !prev) break;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int per, hi, highs, first, second;
    #1 rstN = 1'b0;
    idle(3);
    // R9 reset state
    chk("R9 status after reset", statusByte, 8'h00);
    chk("R9 irqOeN after reset", irqOeN, 1);
    chk("R9 sqwOut after reset", sqwOut, 0);
    chk("R5 irqLine tied low", irqLine, 0);
    @(negedge clk); rstN = 1'b1;

    // R5 table: rate off, divider running
    wrA(8'h20);
    for (int k = 0; k < 8; k++) begin
      readC(v);
      wrB({2'b00, VEC[k][11], VEC[k][10], 4'b0000});
      pulseEv(VEC[k][9], VEC[k][8]);
      chk($sformatf("R5 status vec %0d", k), statusByte, VEC[k][7:0]);
      chk($sformatf("R5 irqOeN vec %0d", k), irqOeN, VEC[k][7] ? 0 : 1);
      readC(v);
      chk($sformatf("R6 read value vec %0d", k), v, VEC[k][7:0]);
      chk($sformatf("R6 cleared vec %0d", k), statusByte, 8'h00);
    end

    // R3 hold pattern keeps chain at zero
    wrA(8'h63); wrB(8'h08); readC(v);
    highs = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (sqwOut) highs++; end
    chk("R3 held chain gives no square wave", highs, 0);
    readC(v);
    chk("R3 held chain gives no periodic flag", v, 8'h00);

    // R1/R2 periods
    wrA(8'h23); measure(per, hi);
    chk("R1 code 3 period", per, 4);  chk("R2 code 3 high time", hi, 2);
    wrA(8'h24); measure(per, hi);
    chk("R1 code 4 period", per, 8);  chk("R2 code 4 high time", hi, 4);
    wrA(8'h21); measure(per, hi);
    chk("R1 code 1 period", per, 128); chk("R2 code 1 high time", hi, 64);
    wrA(8'h22); measure(per, hi);
    chk("R1 code 2 period", per, 256); chk("R2 code 2 high time", hi, 128);

    // R2 enable off
    wrA(8'h23); wrB(8'h00);
    highs = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (sqwOut) highs++; end
    chk("R2 square wave low when disabled", highs, 0);

    // R1 code 0 gives nothing
    wrA(8'h20); wrB(8'h08); readC(v); idle(300);
    highs = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (sqwOut) highs++; end
    chk("R1 code 0 no square wave", highs, 0);
    readC(v);
    chk("R1 code 0 no periodic flag", v, 8'h00);

    // R4 periodic flag without enable, then R5 immediate assertion
    wrB(8'h00); wrA(8'h23); idle(10);
    chk("R4 periodic flag sets without enable", statusByte, 8'h40);
    chk("R4 no request without enable", irqOeN, 1);
    wrB(8'h40);
    chk("R5 enabling set flag asserts at once", irqOeN, 0);
    chk("R5 summary bit with periodic", statusByte, 8'hC0);
    wrB(8'h00); wrA(8'h20); readC(v); readC(v);
    chk("R6 clean before hold test", statusByte, 8'h00);

    // R6/R7 event during a read
    pulseEv(1'b1, 1'b0);
    @(negedge clk); statRd = 1'b1;
    @(negedge clk);
    chk("R6 held byte at read start", statusByte, 8'h20);
    updEv = 1'b1; @(negedge clk); updEv = 1'b0;
    chk("R7 held byte ignores mid-read event", statusByte, 8'h20);
    @(negedge clk);
    chk("R7 held byte still stable", statusByte, 8'h20);
    statRd = 1'b0; @(negedge clk);
    chk("R7 mid-read event posted after read", statusByte, 8'h10);
    readC(v);

    // R8 freeze-updates clears update enable
    wrB(8'h90); pulseEv(1'b0, 1'b1);
    chk("R8 update enable cleared by freeze write", irqOeN, 1);
    chk("R8 status without summary", statusByte, 8'h10);
    wrB(8'h10);
    chk("R5 update request asserts on enable", irqOeN, 0);
    chk("R5 update summary", statusByte, 8'h90);
    readC(v); wrB(8'h00);

    // R9 reset clears enables, keeps rate code
    wrB(8'h68); wrA(8'h23); pulseEv(1'b1, 1'b0);
    chk("R9 alarm request before reset", irqOeN, 0);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    chk("R9 request released in reset", irqOeN, 1);
    chk("R9 status cleared in reset", statusByte, 8'h00);
    rstN = 1'b1;
    highs = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (sqwOut) highs++; end
    chk("R9 square-wave enable cleared", highs, 0);
    chk("R9 rate kept, periodic enable cleared", statusByte, 8'h40);
    chk("R9 no request after reset", irqOeN, 1);
    pulseEv(1'b1, 1'b0);
    chk("R9 alarm enable cleared", irqOeN, 1);
    wrA(8'h20); readC(v);

    // R3 one-second strobe timing
    wrA(8'h60); wrA(8'h20);
    first = 0; second = 0;
    for (int n = 1; n <= 60000; n++) begin
      @(posedge clk); @(negedge clk);
      if (secTick) begin
        if (first == 0) first = n;
        else if (second == 0) begin second = n; break; end
      end
    end
    chk("R3 first second strobe delay", first, 16384);
    chk("R3 second strobe spacing", second - first, 32768);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule